// File: doc/BRIEF.md
# Matrix Keypad Column Scanner

This block reads a square grid of push buttons that sits between a set of column lines and a set of row lines. A pressed button joins its row line to its column line. The scanner selects one column at a time by pulling it low. It waits a programmable settle time, then captures the row lines, which read low wherever a button in the selected column is held. It then moves on to the next column. After the last column it starts again at the first, so the scan never stops. Each column's sample is kept in a pressed-button map, and a one-cycle strobe marks the end of every complete pass.

The block has two column drive styles, chosen by an input. In drive mode, every column line is actively driven and the unselected columns are held high. In float mode, only the selected column is driven (low). The others are released and rely on external pull-ups. This lets several buttons in one row be held at once without two driven columns fighting through them. The row inputs are asynchronous, so they pass through a two-stage synchronizer before they are sampled.

Top module: `kscan_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, column 0 is the selected column, the key map is all zero, and the scan-done strobe is low.
- R2: At every cycle exactly one column is actively pulled low, meaning its output enable is 1 and its output value is 0.
- R3: With floatMode = 0, every column output enable is 1 and every unselected column outputs 1.
- R4: With floatMode = 1, only the selected column has its output enable at 1. All other enables are 0.
- R5: A column stays selected for exactly SETTLE_CYCLES clock cycles. Selection then moves to the next index and wraps from NUM_COLS-1 back to 0. After reset, column (k / SETTLE_CYCLES) mod NUM_COLS is selected once k clock edges have passed.
- R6: On the last cycle of a column's dwell, the synchronized rows are inverted and stored. Bit NUM_ROWS*c + r of keyMap is 1 when the button at row r, column c is pressed (rowN[r] low while column c is selected). keyMap changes only on those cycles.
- R7: scanDone is high for exactly one cycle, on the cycle after the last column has been sampled. It recurs every NUM_COLS*SETTLE_CYCLES cycles.
- R8: In float mode, any number of buttons pressed in the same row are all reported in keyMap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| floatMode | input | 1 | 0: drive idle columns high; 1: release idle columns to pull-ups |
| rowN | input | NUM_ROWS | Row lines, active low, asynchronous |
| colOut | output | NUM_COLS | Output value for each column line |
| colOe | output | NUM_COLS | Output enable for each column line |
| keyMap | output | NUM_ROWS*NUM_COLS | Pressed-button map, 1 = pressed |
| scanDone | output | 1 | One-cycle strobe after each full pass |

## Verification
The bench builds the scanner with a 4x4 grid and SETTLE_CYCLES set to 8 instead of 1000. A full pass then takes 32 cycles. This brings dozens of wraps, both drive modes and many complete scans within a short run. Eight cycles is still well above the two-stage synchronizer latency, so captured rows always reflect the newly selected column. A model keypad in the bench pulls rows low only through columns that are both enabled and driven low. The expected map is therefore exactly the pressed pattern, including full rows pressed in float mode.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic sample;   // last cycle of the current column dwell
    logic lastCol;  // the selected column is the final one
  } scanStrobe_t;

endpackage

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int NUM_COLS      = 4,
  parameter int SETTLE_CYCLES = 1000,
  parameter int COL_W         = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] colIdx,
  output scanStrobe_t      strobe
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    strobe.sample  = (settleCnt == CNT_LAST);
    strobe.lastCol = (colIdx == COL_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      colIdx    <= '0;
    end else if (strobe.sample) begin
      settleCnt <= '0;
      colIdx    <= strobe.lastCol ? '0 : colIdx + 1'b1;
    end else begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/kscan_datapath.sv
module kscan_datapath
  import kscan_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  parameter int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         floatMode,
  input  logic [NUM_ROWS-1:0]          rowN,
  input  logic [COL_W-1:0]             colIdx,
  input  scanStrobe_t                  strobe,
  output logic [NUM_COLS-1:0]          colOut,
  output logic [NUM_COLS-1:0]          colOe,
  output logic [NUM_ROWS*NUM_COLS-1:0] keyMap,
  output logic                         scanDone
);

  logic [NUM_ROWS-1:0] rowMeta;
  logic [NUM_ROWS-1:0] rowSync;

  // Two-stage synchronizer; idle level is released (high)
  always_ff @(posedge clk) begin
    if (rst) begin
      rowMeta <= '1;
      rowSync <= '1;
    end else begin
      rowMeta <= rowN;
      rowSync <= rowMeta;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic selHere;
    logic [NUM_ROWS-1:0] bitsQ;

    assign selHere   = (colIdx == COL_W'(c));
    assign colOut[c] = ~selHere;
    assign colOe[c]  = ~floatMode | selHere;

    always_ff @(posedge clk) begin
      if (rst)                          bitsQ <= '0;
      else if (strobe.sample && selHere) bitsQ <= ~rowSync;
    end

    assign keyMap[c*NUM_ROWS +: NUM_ROWS] = bitsQ;
  end

  always_ff @(posedge clk) begin
    if (rst) scanDone <= 1'b0;
    else     scanDone <= strobe.sample & strobe.lastCol;
  end

endmodule

// File: rtl/kscan_top.sv
module kscan_top
  import kscan_pkg::*;
#(
  parameter int NUM_ROWS      = 4,
  parameter int NUM_COLS      = 4,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         floatMode,
  input  logic [NUM_ROWS-1:0]          rowN,
  output logic [NUM_COLS-1:0]          colOut,
  output logic [NUM_COLS-1:0]          colOe,
  output logic [NUM_ROWS*NUM_COLS-1:0] keyMap,
  output logic                         scanDone
);

  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

  logic [COL_W-1:0] colIdx;
  scanStrobe_t      strobe;

  kscan_ctrl #(
    .NUM_COLS(NUM_COLS), .SETTLE_CYCLES(SETTLE_CYCLES), .COL_W(COL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .colIdx(colIdx), .strobe(strobe)
  );

  kscan_datapath #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .COL_W(COL_W)
  ) u_dp (
    .clk(clk), .rst(rst), .floatMode(floatMode), .rowN(rowN),
    .colIdx(colIdx), .strobe(strobe), .colOut(colOut), .colOe(colOe),
    .keyMap(keyMap), .scanDone(scanDone)
  );

endmodule

// File: rtl/kscan_checker.sv
module kscan_checker #(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         floatMode,
  input logic [NUM_COLS-1:0]          colOut,
  input logic [NUM_COLS-1:0]          colOe,
  input logic [NUM_ROWS*NUM_COLS-1:0] keyMap,
  input logic                         scanDone
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (keyMap == '0 && !scanDone));

  a_r2_one_active: assert property (@(posedge clk) disable iff (rst)
    $countones(colOe & ~colOut) == 1);

  a_r3_drive_all: assert property (@(posedge clk) disable iff (rst)
    !floatMode |-> (&colOe));

  a_r4_float_single: assert property (@(posedge clk) disable iff (rst)
    floatMode |-> ($countones(colOe) == 1));

  a_r5_wrap_first: assert property (@(posedge clk) disable iff (rst)
    scanDone |-> (colOut[0] == 1'b0));

  a_r6_map_on_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(keyMap) |-> !$stable(colOut));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    scanDone |=> !scanDone);

endmodule

bind kscan_top kscan_checker #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_chk (
  .clk(clk), .rst(rst), .floatMode(floatMode), .colOut(colOut),
  .colOe(colOe), .keyMap(keyMap), .scanDone(scanDone)
);

// File: tb/kscan_top_bench.sv
module kscan_top_bench;

  localparam int NR = 4;
  localparam int NC = 4;
  localparam int ST = 8;
  localparam int PASS = NC * ST;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic floatMode = 1'b0;
  logic [NR-1:0] rowN;
  logic [NC-1:0] colOut, colOe;
  logic [NR*NC-1:0] keyMap;
  logic scanDone;
  logic [NR*NC-1:0] pressed = '0;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  int cycTotal = 0;

  always #5 clk = ~clk;

  kscan_top #(.NUM_ROWS(NR), .NUM_COLS(NC), .SETTLE_CYCLES(ST)) u_kscan_top (
    .clk(clk), .rst(rst), .floatMode(floatMode), .rowN(rowN),
    .colOut(colOut), .colOe(colOe), .keyMap(keyMap), .scanDone(scanDone)
  );

  // Keypad model: a row reads low only via a column enabled and driven low
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rowN[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (pressed[c*NR+r] && colOe[c] && !colOut[c]) rowN[r] = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] expOut(int k);
    return ~(NC'(1) << ((k / ST) % NC));
  endfunction

  function automatic logic [NC-1:0] expOe(int k, logic fm);
    return fm ? (NC'(1) << ((k / ST) % NC)) : '1;
  endfunction

  always @(posedge clk) begin
    cycTotal <= cycTotal + 1;
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  // Per-cycle monitor of column drive and done timing
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 colOut", 32'(colOut), 32'(expOut(edges)));
      check(floatMode ? "R4 colOe" : "R3 colOe", 32'(colOe), 32'(expOe(edges, floatMode)));
      check("R7 scanDone", 32'(scanDone), 32'(edges > 0 && edges % PASS == 0));
    end
  end

  always @(posedge clk) begin
    if (cycTotal > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycTotal);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitDone();
    do @(negedge clk); while (!scanDone);
  endtask

  task automatic runPattern(input logic [NR*NC-1:0] pat, input logic fm, input string req);
    @(posedge clk); #1;
    pressed = pat;
    floatMode = fm;
    waitDone();
    waitDone();
    check(req, 32'(keyMap), 32'(pat));
  endtask

  initial begin
    logic [31:0] seedv;
    seedv = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 keyMap", 32'(keyMap), 32'h0);
    check("R1 colOut", 32'(colOut), 32'he);
    check("R1 scanDone", 32'(scanDone), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 32'(keyMap), 32'h0);
    // Directed corners
    runPattern(16'h0000, 1'b0, "R6 none pressed");
    runPattern(16'h8001, 1'b0, "R6 corner keys");
    runPattern(16'h1111, 1'b1, "R8 full row 0 float");
    runPattern(16'h8888, 1'b1, "R8 full row 3 float");
    runPattern(16'hFFFF, 1'b1, "R8 all pressed float");
    runPattern(16'h00F0, 1'b0, "R6 full column 1");
    // Random patterns, both modes
    for (int i = 0; i < 16; i++)
      runPattern(16'($urandom), 1'(i % 2), "R6 random map");
    runPattern(16'h0000, 1'b0, "R6 release all");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule